// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer

This block drives the two gate enables of one half-bridge output stage. Software sets separate high-side and low-side request bits. An enable bit decides whether an external PWM signal also qualifies the requests. The block turns these requests into a high-side gate and a low-side gate that can never conduct together. When one side switches off, the opposite side cannot switch on until a cross-conduction interval, counted in clock ticks, has passed. Slew-rate shaping of the power stage is not modelled; the interval stands in for it.

Several conditions force both gates off: a thermal-shutdown flag, a supply over- or undervoltage condition, standby, and a start-up settling window that follows every exit from standby. A `not_ready` output is high during standby and during the settling window. After a supply fault clears, the block can return the output to its programmed state on its own once the fault has stayed absent for a set time. It can instead hold the output off until software acknowledges the fault.

Top module: `hb_gate_seq`

## Requirements
- R1: While reset is asserted and right after it, `hs_gate` and `ls_gate` are 0 and `not_ready` is 1.
- R2: `hs_gate` and `ls_gate` are never 1 in the same cycle.
- R3: With `pwm_en`=0 and no inhibit or block active, a request on one side alone sets that gate at the next rising edge. Dropping the request clears the gate at the next rising edge.
- R4: With `pwm_en`=1, each side's effective request is its request bit ANDed with `pwm_in`. The gate follows the effective request one rising edge later.
- R5: After a gate falls at edge E0, the opposite gate stays 0 at edges E1 to E(DEAD_TICKS). It may rise at edge E(DEAD_TICKS+1) at the earliest. The gate that fell may rise again at once.
- R6: If another turn-off happens while the cross-conduction interval is still running, the interval restarts from that turn-off.
- R7: When both effective requests are 1, the side that is already on stays on. If neither side is on, both gates stay 0.
- R8: While `tsd_flag` is 1, both gates go to 0 at the next edge and stay 0. Once `tsd_flag` is 0, the programmed state returns.
- R9: `sup_fault`=1 forces both gates to 0 at the next edge. With `recov_dis`=0, the block lifts on the REC_TICKS-th consecutive edge at which `sup_fault` is sampled 0, so a gate can rise one edge later. A fault seen again during this count restarts it.
- R10: With `recov_dis`=1, a supply block stays in place after the fault clears. It lifts only at an edge where `sup_ack`=1 and `sup_fault`=0. An `sup_ack` seen while the fault is still present is ignored.
- R11: While `active`=0, both gates are 0 and `not_ready` is 1. After `active` is first sampled 1, `not_ready` stays 1 until the START_TICKS-th edge with `active`=1, and the gates stay 0 until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_req | input | 1 | High-side on request |
| ls_req | input | 1 | Low-side on request |
| pwm_en | input | 1 | 1: requests are ANDed with `pwm_in` |
| pwm_in | input | 1 | External PWM signal |
| tsd_flag | input | 1 | Latched thermal-shutdown flag |
| sup_fault | input | 1 | Supply over/undervoltage condition present |
| recov_dis | input | 1 | 1: supply block needs an acknowledge to lift |
| sup_ack | input | 1 | Software acknowledge of a supply block |
| active | input | 1 | 1: active mode, 0: standby |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |
| not_ready | output | 1 | Standby or start-up settling in progress |

## Verification
The hardest case to reach from the ports is a cross-conduction interval that restarts. The same side has to turn off, turn back on and turn off again before the interval expires, while the opposite side is already waiting. The stimulus does this by pulsing the low-side request twice within a few cycles and then handing over to the high side. It also breaks a supply recovery count partway with a one-cycle fault and sends an acknowledge while the fault is still present. A cycle-accurate reference model compares both gates and `not_ready` on every clock.

// File: rtl/hb_pkg.sv
package hb_pkg;
   typedef enum logic [1:0] {
      SIDE_NONE = 2'd0,
      SIDE_HI   = 2'd1,
      SIDE_LO   = 2'd2
   } side_e;

   localparam int unsigned N_SIDES = 2;
   localparam int unsigned IDX_HI  = 0;
   localparam int unsigned IDX_LO  = 1;
endpackage

// File: rtl/hb_pwm_qual.sv
module hb_pwm_qual #(
   parameter int unsigned N_SIDES = 2
) (
   input  logic [N_SIDES-1:0] req,
   input  logic               pwm_en,
   input  logic               pwm_in,
   output logic [N_SIDES-1:0] qual
);
   genvar gi;
   generate
      for (gi = 0; gi < N_SIDES; gi++) begin : g_side
         assign qual[gi] = req[gi] & (pwm_en ? pwm_in : 1'b1);
      end
   endgenerate
endmodule

// File: rtl/hb_supply_guard.sv
module hb_supply_guard #(
   parameter int unsigned REC_TICKS = 1600
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sup_fault,
   input  logic recov_dis,
   input  logic sup_ack,
   output logic blocked
);
   localparam int unsigned RW = $clog2(REC_TICKS + 1);
   localparam logic [RW-1:0] LAST = RW'(REC_TICKS - 1);

   logic [RW-1:0] clean_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blocked   <= 1'b0;
         clean_cnt <= '0;
      end else if (sup_fault) begin
         blocked   <= 1'b1;
         clean_cnt <= '0;
      end else if (blocked) begin
         if (recov_dis) begin
            if (sup_ack) begin
               blocked   <= 1'b0;
               clean_cnt <= '0;
            end
         end else if (clean_cnt == LAST) begin
            blocked   <= 1'b0;
            clean_cnt <= '0;
         end else begin
            clean_cnt <= clean_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/hb_startup_timer.sv
module hb_startup_timer #(
   parameter int unsigned START_TICKS = 15000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic not_ready
);
   localparam int unsigned SW = $clog2(START_TICKS + 1);
   localparam logic [SW-1:0] FULL = SW'(START_TICKS);

   logic [SW-1:0] settle_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         settle_cnt <= FULL;
      end else if (!active) begin
         settle_cnt <= FULL;
      end else if (settle_cnt != '0) begin
         settle_cnt <= settle_cnt - 1'b1;
      end
   end

   assign not_ready = (settle_cnt != '0);
endmodule

// File: rtl/hb_interlock.sv
module hb_interlock
   import hb_pkg::*;
#(
   parameter int unsigned DEAD_TICKS = 15000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic want_hi,
   input  logic want_lo,
   input  logic inhibit,
   output logic hs_gate,
   output logic ls_gate
);
   localparam int unsigned DW = $clog2(DEAD_TICKS + 1);
   localparam logic [DW-1:0] DEAD_LD = DW'(DEAD_TICKS);

   logic [DW-1:0] dead_cnt;
   side_e         last_off;
   side_e         target;
   logic          hi_eff, lo_eff;
   logic          hi_held, lo_held;
   logic          hs_d, ls_d;

   always_comb begin
      hi_eff = want_hi & ~inhibit;
      lo_eff = want_lo & ~inhibit;
      if (hi_eff && lo_eff) begin
         if (hs_gate)      target = SIDE_HI;
         else if (ls_gate) target = SIDE_LO;
         else              target = SIDE_NONE;
      end else if (hi_eff) begin
         target = SIDE_HI;
      end else if (lo_eff) begin
         target = SIDE_LO;
      end else begin
         target = SIDE_NONE;
      end
      hi_held = (dead_cnt != '0) && (last_off == SIDE_LO);
      lo_held = (dead_cnt != '0) && (last_off == SIDE_HI);
      hs_d    = (target == SIDE_HI) && !ls_gate && !hi_held;
      ls_d    = (target == SIDE_LO) && !hs_gate && !lo_held;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_gate  <= 1'b0;
         ls_gate  <= 1'b0;
         dead_cnt <= '0;
         last_off <= SIDE_NONE;
      end else begin
         hs_gate <= hs_d;
         ls_gate <= ls_d;
         if (hs_gate && !hs_d) begin
            dead_cnt <= DEAD_LD;
            last_off <= SIDE_HI;
         end else if (ls_gate && !ls_d) begin
            dead_cnt <= DEAD_LD;
            last_off <= SIDE_LO;
         end else if (dead_cnt != '0) begin
            dead_cnt <= dead_cnt - 1'b1;
         end
      end
   end
endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
   import hb_pkg::*;
#(
   parameter int unsigned DEAD_TICKS  = 15000,
   parameter int unsigned REC_TICKS   = 1600,
   parameter int unsigned START_TICKS = 15000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hs_req,
   input  logic ls_req,
   input  logic pwm_en,
   input  logic pwm_in,
   input  logic tsd_flag,
   input  logic sup_fault,
   input  logic recov_dis,
   input  logic sup_ack,
   input  logic active,
   output logic hs_gate,
   output logic ls_gate,
   output logic not_ready
);
   initial begin : param_guard
      if (DEAD_TICKS < 1)  $fatal(1, "DEAD_TICKS must be at least 1");
      if (REC_TICKS < 1)   $fatal(1, "REC_TICKS must be at least 1");
      if (START_TICKS < 1) $fatal(1, "START_TICKS must be at least 1");
   end

   logic [N_SIDES-1:0] raw_req;
   logic [N_SIDES-1:0] qual_req;
   logic               sup_blocked;
   logic               settling;
   logic               inhibit;

   assign raw_req[IDX_HI] = hs_req;
   assign raw_req[IDX_LO] = ls_req;

   hb_pwm_qual #(.N_SIDES(N_SIDES)) u_qual (
      .req    (raw_req),
      .pwm_en (pwm_en),
      .pwm_in (pwm_in),
      .qual   (qual_req)
   );

   hb_supply_guard #(.REC_TICKS(REC_TICKS)) u_sup (
      .clk       (clk),
      .rst_n     (rst_n),
      .sup_fault (sup_fault),
      .recov_dis (recov_dis),
      .sup_ack   (sup_ack),
      .blocked   (sup_blocked)
   );

   hb_startup_timer #(.START_TICKS(START_TICKS)) u_start (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active),
      .not_ready (settling)
   );

   assign inhibit = tsd_flag | sup_fault | sup_blocked | ~active | settling;

   hb_interlock #(.DEAD_TICKS(DEAD_TICKS)) u_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .want_hi (qual_req[IDX_HI]),
      .want_lo (qual_req[IDX_LO]),
      .inhibit (inhibit),
      .hs_gate (hs_gate),
      .ls_gate (ls_gate)
   );

   assign not_ready = settling;
endmodule

// File: rtl/hb_gate_seq_chk.sv
module hb_gate_seq_chk #(
   parameter int unsigned DEAD_TICKS = 15000
) (
   input logic clk,
   input logic rst_n,
   input logic hs_req,
   input logic ls_req,
   input logic pwm_en,
   input logic pwm_in,
   input logic tsd_flag,
   input logic sup_fault,
   input logic active,
   input logic hs_gate,
   input logic ls_gate,
   input logic not_ready
);
   localparam int unsigned AW = $clog2(DEAD_TICKS + 1);
   localparam logic [AW-1:0] LIM = AW'(DEAD_TICKS);

   logic [AW-1:0] hs_age, ls_age;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_age <= LIM;
         ls_age <= LIM;
      end else begin
         if (hs_gate)          hs_age <= '0;
         else if (hs_age < LIM) hs_age <= hs_age + 1'b1;
         if (ls_gate)          ls_age <= '0;
         else if (ls_age < LIM) ls_age <= ls_age + 1'b1;
      end
   end

   p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_gate && ls_gate));

   p_hs_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !hs_req |=> !hs_gate);

   p_ls_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ls_req |=> !ls_gate);

   p_pwm_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_en && !pwm_in) |=> (!hs_gate && !ls_gate));

   p_hs_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!hs_gate && (ls_age < LIM)) |=> !hs_gate);

   p_ls_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ls_gate && (hs_age < LIM)) |=> !ls_gate);

   p_tsd_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tsd_flag |=> (!hs_gate && !ls_gate));

   p_sup_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sup_fault |=> (!hs_gate && !ls_gate));

   p_standby_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (!hs_gate && !ls_gate && not_ready));
endmodule

bind hb_gate_seq hb_gate_seq_chk #(.DEAD_TICKS(DEAD_TICKS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hs_req    (hs_req),
   .ls_req    (ls_req),
   .pwm_en    (pwm_en),
   .pwm_in    (pwm_in),
   .tsd_flag  (tsd_flag),
   .sup_fault (sup_fault),
   .active    (active),
   .hs_gate   (hs_gate),
   .ls_gate   (ls_gate),
   .not_ready (not_ready)
);

// File: tb/hb_gate_seq_bench.sv
module hb_gate_seq_bench;
   localparam int DEAD  = 5;
   localparam int REC   = 7;
   localparam int START = 6;

   logic clk = 1'b0;
   logic rst_n;
   logic hs_req, ls_req, pwm_en, pwm_in, tsd_flag;
   logic sup_fault, recov_dis, sup_ack, active;
   logic hs_gate, ls_gate, not_ready;

   int n_chk  = 0;
   int n_fail = 0;
   string cur_req = "R1";
   bit done = 1'b0;

   always #10 clk = ~clk;

   hb_gate_seq #(.DEAD_TICKS(DEAD), .REC_TICKS(REC), .START_TICKS(START)) u_hb_gate_seq (
      .clk(clk), .rst_n(rst_n), .hs_req(hs_req), .ls_req(ls_req),
      .pwm_en(pwm_en), .pwm_in(pwm_in), .tsd_flag(tsd_flag),
      .sup_fault(sup_fault), .recov_dis(recov_dis), .sup_ack(sup_ack),
      .active(active), .hs_gate(hs_gate), .ls_gate(ls_gate),
      .not_ready(not_ready)
   );

   // behavioural reference
   bit m_hs, m_ls, m_blk;
   int m_age, m_off, m_abs, m_run;

   always @(posedge clk) begin
      bit inh, he, le, hn, ln;
      int want;
      if (!rst_n) begin
         m_hs = 0; m_ls = 0; m_blk = 0;
         m_age = DEAD; m_off = 0; m_abs = 0; m_run = 0;
      end else begin
         inh = tsd_flag || sup_fault || m_blk || !active || (m_run < START);
         he = hs_req && (!pwm_en || pwm_in) && !inh;
         le = ls_req && (!pwm_en || pwm_in) && !inh;
         if (he && le) want = m_hs ? 1 : (m_ls ? 2 : 0);
         else if (he)  want = 1;
         else if (le)  want = 2;
         else          want = 0;
         hn = (want == 1) && !m_ls && !(m_age < DEAD && m_off == 2);
         ln = (want == 2) && !m_hs && !(m_age < DEAD && m_off == 1);
         if (m_hs && !hn)      begin m_age = 0; m_off = 1; end
         else if (m_ls && !ln) begin m_age = 0; m_off = 2; end
         else if (m_age < DEAD) m_age++;
         if (sup_fault) begin
            m_blk = 1; m_abs = 0;
         end else begin
            m_abs++;
            if (m_blk && !recov_dis && m_abs >= REC) m_blk = 0;
            else if (m_blk && recov_dis && sup_ack) m_blk = 0;
         end
         if (!active) m_run = 0;
         else if (m_run < START) m_run++;
         m_hs = hn; m_ls = ln;
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         check(cur_req, "hs_gate", int'(hs_gate), int'(m_hs));
         check(cur_req, "ls_gate", int'(ls_gate), int'(m_ls));
         check(cur_req, "not_ready", int'(not_ready), int'(m_run < START));
         check("R2", "overlap", int'(hs_gate && ls_gate), 0);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      rst_n = 0; hs_req = 0; ls_req = 0; pwm_en = 0; pwm_in = 0;
      tsd_flag = 0; sup_fault = 0; recov_dis = 0; sup_ack = 0; active = 0;
      cyc(3);
      check("R1", "reset hs", int'(hs_gate), 0);
      check("R1", "reset ls", int'(ls_gate), 0);
      check("R1", "reset not_ready", int'(not_ready), 1);
      rst_n = 1;
      // R11: standby, then settling window
      cur_req = "R11"; hs_req = 1; cyc(3);
      active = 1; cyc(START + 4);
      // R3: single-side requests
      cur_req = "R3"; hs_req = 0; cyc(DEAD + 3);
      ls_req = 1; cyc(4); ls_req = 0; cyc(DEAD + 3);
      // R5: hand-over low to high
      cur_req = "R5"; ls_req = 1; cyc(3);
      ls_req = 0; hs_req = 1; cyc(DEAD + 5);
      // R7: both requested
      cur_req = "R7"; ls_req = 1; cyc(5);
      hs_req = 0; ls_req = 0; cyc(DEAD + 4);
      hs_req = 1; ls_req = 1; cyc(6);
      hs_req = 0; ls_req = 0; cyc(2);
      // R6: restart of the interval
      cur_req = "R6"; ls_req = 1; cyc(4);
      ls_req = 0; cyc(2); ls_req = 1; cyc(2);
      ls_req = 0; hs_req = 1; cyc(DEAD + 5);
      // R4: PWM gating
      cur_req = "R4"; pwm_en = 1;
      for (int i = 0; i < 18; i++) begin
         pwm_in = (i % 3) != 0;
         cyc(1);
      end
      pwm_en = 0; cyc(3);
      // R8: thermal shutdown
      cur_req = "R8"; tsd_flag = 1; cyc(5); tsd_flag = 0; cyc(4);
      // R9: supply fault with auto recovery, interrupted once
      cur_req = "R9"; sup_fault = 1; cyc(3);
      sup_fault = 0; cyc(4); sup_fault = 1; cyc(1);
      sup_fault = 0; cyc(REC + 4);
      // R10: recovery needs acknowledge
      cur_req = "R10"; recov_dis = 1; sup_fault = 1; cyc(2);
      sup_fault = 0; cyc(REC + 5);
      sup_fault = 1; sup_ack = 1; cyc(1);
      sup_fault = 0; sup_ack = 0; cyc(4);
      check("R10", "held off after late ack", int'(hs_gate), 0);
      sup_ack = 1; cyc(1); sup_ack = 0; cyc(4);
      check("R10", "on after ack", int'(hs_gate), 1);
      recov_dis = 0; hs_req = 0; cyc(3);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule